// File: doc/BRIEF.md
# Register File with Optional Hardwired Zero Word

This block stores a parameterised number of words, each `WIDTH` bits wide. It has one write port and one read port, each with its own address. A write lands on the rising clock edge in the word named by the write address. The write data comes from one of two input buses, and a one-bit select picks the bus. The read port is combinational. While the read enable is high, the read bus shows the word at the read address. While the read enable is low, the read bus keeps the last value it showed.

A build-time parameter, `ZERO_WORD`, makes word 0 a constant zero. In that variant a write to address 0 is accepted but changes nothing, and a read of address 0 returns zero. With the parameter cleared, word 0 is an ordinary storage word. The storage words have no reset, so their contents are undefined until they are written. Only the register that holds the read bus is cleared by the active-low reset. `WORDS` is expected to be a power of two, so that every address names a word.

Top module: `rfz_regfile`

## Requirements
- R1: With `wr_sel` = 0 the word is written from `wr_data_a`, and with `wr_sel` = 1 it is written from `wr_data_b`.
- R2: On a rising clock edge with `wr_en` = 1, only the word at `wr_addr` takes the selected data. Every other word keeps its value.
- R3: On a rising clock edge with `wr_en` = 0, no word changes, whatever the other write inputs carry.
- R4: While `rd_en` = 1, `rd_data` equals the word at `rd_addr` in the same cycle, with no clock edge in between.
- R5: While `rd_en` = 0, `rd_data` keeps the value it showed at the last rising edge where `rd_en` was 1. Changes on `rd_addr` and writes to storage do not alter it.
- R6: If a read and a write name the same address in one cycle, `rd_data` shows the old contents until the edge. After the edge it shows the new contents.
- R7: With `ZERO_WORD` = 1, a write to address 0 has no effect, and a read of address 0 returns all zeros.
- R8: With `ZERO_WORD` = 0, address 0 stores and returns written data like any other word.
- R9: While `rst_n` is low, and afterwards until the first rising edge with `rd_en` = 1, `rd_data` is zero whenever `rd_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read-hold register |
| wr_sel | input | 1 | Write bus select: 0 picks `wr_data_a`, 1 picks `wr_data_b` |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| rd_addr | input | $clog2(WORDS) | Read address |
| wr_addr | input | $clog2(WORDS) | Write address |
| wr_data_a | input | WIDTH | First write data bus |
| wr_data_b | input | WIDTH | Second write data bus |
| rd_data | output | WIDTH | Read data |

## Verification
The assertions assume three things about the inputs:
- `rd_en` and `wr_en` stay low while `rst_n` is low, so the first edge after reset compares against defined values.
- No word is read before it has been written, because unwritten words hold undefined data.
- Every address stays below `WORDS`.

The stimulus keeps to these assumptions. It holds both enables low through reset and fills every word before the first enabled read. Its addresses come from a range of exactly `WORDS` values. Two instances share the same stimulus, one with the zero word and one without, so each variant is compared against its own model.

// File: rtl/rfz_pkg.sv
package rfz_pkg;
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } wsrc_e;

  function automatic logic [1023:0] pick_src(input wsrc_e src,
                                             input logic [1023:0] a,
                                             input logic [1023:0] b);
    return (src == SRC_B) ? b : a;
  endfunction
endpackage

// File: rtl/rfz_wr_front.sv
module rfz_wr_front #(
  parameter int WORDS     = 8,
  parameter int WIDTH     = 32,
  parameter bit ZERO_WORD = 1'b1,
  localparam int AW       = $clog2(WORDS)
) (
  input  logic                    sel,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [WIDTH-1:0]        din_a,
  input  logic [WIDTH-1:0]        din_b,
  output logic [WORDS-1:0]        word_we,
  output logic [WIDTH-1:0]        wdata
);
  import rfz_pkg::*;

  wsrc_e src;
  logic [1023:0] wide_a, wide_b, wide_q;

  always_comb begin
    src    = sel ? SRC_B : SRC_A;
    wide_a = '0;
    wide_b = '0;
    wide_a[WIDTH-1:0] = din_a;
    wide_b[WIDTH-1:0] = din_b;
    wide_q = pick_src(src, wide_a, wide_b);
    wdata  = wide_q[WIDTH-1:0];
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_dec
    if (ZERO_WORD && i == 0) begin : g_masked
      assign word_we[i] = 1'b0;
    end else begin : g_live
      assign word_we[i] = we && (waddr == AW'(i));
    end
  end
endmodule

// File: rtl/rfz_array.sv
module rfz_array #(
  parameter int WORDS     = 8,
  parameter int WIDTH     = 32,
  parameter bit ZERO_WORD = 1'b1
) (
  input  logic                        clk,
  input  logic [WORDS-1:0]            word_we,
  input  logic [WIDTH-1:0]            wdata,
  output logic [WORDS-1:0][WIDTH-1:0] words
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (ZERO_WORD && i == 0) begin : g_const
      assign words[i] = '0;
    end else begin : g_store
      logic [WIDTH-1:0] word_q, word_d;

      always_comb begin
        word_d = word_q;
        if (word_we[i]) word_d = wdata;
      end

      always_ff @(posedge clk) begin
        word_q <= word_d;
      end

      assign words[i] = word_q;
    end
  end
endmodule

// File: rtl/rfz_rd_port.sv
module rfz_rd_port #(
  parameter int WORDS = 8,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        re,
  input  logic [AW-1:0]               raddr,
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  output logic [WIDTH-1:0]            dout
);
  logic [WIDTH-1:0] sel_word;
  logic [WIDTH-1:0] hold_q, hold_d;

  always_comb begin
    sel_word = words[raddr];
    hold_d   = hold_q;
    if (re) hold_d = sel_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign dout = re ? sel_word : hold_q;
endmodule

// File: rtl/rfz_regfile.sv
module rfz_regfile #(
  parameter int WORDS     = 8,
  parameter int WIDTH     = 32,
  parameter bit ZERO_WORD = 1'b1,
  localparam int AW       = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data_a,
  input  logic [WIDTH-1:0] wr_data_b,
  output logic [WIDTH-1:0] rd_data
);
  logic [WORDS-1:0]            word_we;
  logic [WIDTH-1:0]            wdata;
  logic [WORDS-1:0][WIDTH-1:0] words;

  rfz_wr_front #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD(ZERO_WORD)) u_front (
    .sel     (wr_sel),
    .we      (wr_en),
    .waddr   (wr_addr),
    .din_a   (wr_data_a),
    .din_b   (wr_data_b),
    .word_we (word_we),
    .wdata   (wdata)
  );

  rfz_array #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD(ZERO_WORD)) u_array (
    .clk     (clk),
    .word_we (word_we),
    .wdata   (wdata),
    .words   (words)
  );

  rfz_rd_port #(.WORDS(WORDS), .WIDTH(WIDTH)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .re    (rd_en),
    .raddr (rd_addr),
    .words (words),
    .dout  (rd_data)
  );
endmodule

// File: rtl/rfz_checker.sv
module rfz_checker #(
  parameter int WORDS     = 8,
  parameter int WIDTH     = 32,
  parameter bit ZERO_WORD = 1'b1,
  localparam int AW       = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data_a,
  input logic [WIDTH-1:0] wr_data_b,
  input logic [WIDTH-1:0] rd_data
);
  // R1 and R2: a word written at the last edge reads back with the chosen bus value
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_en && rd_addr == $past(wr_addr) && !(ZERO_WORD && rd_addr == '0))
    |-> rd_data == ($past(wr_sel) ? $past(wr_data_b) : $past(wr_data_a)));

  // R3: with no write at the last edge, the same address reads the same value
  assert_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && rd_addr == $past(rd_addr) && !$past(wr_en))
    |-> rd_data == $past(rd_data));

  // R5: a disabled read keeps the value from the previous cycle
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == $past(rd_data));

  // R9: the read bus is cleared when reset is released with reads disabled
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !rd_en) |-> rd_data == '0);

  if (ZERO_WORD) begin : g_zero_chk
    // R7: address 0 always reads as zero
    assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == '0) |-> rd_data == '0);
  end
endmodule

bind rfz_regfile rfz_checker #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD(ZERO_WORD)) u_chk (.*);

// File: tb/rfz_regfile_test.sv
`timescale 1ns/1ps
module rfz_regfile_test;
  localparam int W = 32;
  localparam int N = 8;
  localparam int A = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [A-1:0] rd_addr = '0, wr_addr = '0;
  logic [W-1:0] wr_data_a = '0, wr_data_b = '0;
  logic [W-1:0] rd_z, rd_p;

  int compared = 0;
  int mismatched = 0;

  logic [W-1:0] mz [N];
  logic [W-1:0] mp [N];
  logic [W-1:0] hz = '0, hp = '0;

  always #4 clk = ~clk;

  rfz_regfile #(.WORDS(N), .WIDTH(W), .ZERO_WORD(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_en(wr_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data_a(wr_data_a),
    .wr_data_b(wr_data_b), .rd_data(rd_z));

  rfz_regfile #(.WORDS(N), .WIDTH(W), .ZERO_WORD(1'b0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_en(wr_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data_a(wr_data_a),
    .wr_data_b(wr_data_b), .rd_data(rd_p));

  task automatic cmp(input string tag, input string who,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s (%s): rd_data=%h expected=%h at %0t", tag, who, act, exp, $time);
    end
  endtask

  // one cycle: drive at the falling edge, compare before the rising edge, then advance the models
  task automatic cyc(input logic s, input logic w, input logic r,
                     input int wa, input int ra,
                     input logic [W-1:0] a, input logic [W-1:0] b,
                     input string tag);
    logic [W-1:0] ez, ep, wd;
    @(negedge clk);
    wr_sel = s; wr_en = w; rd_en = r;
    wr_addr = A'(wa); rd_addr = A'(ra);
    wr_data_a = a; wr_data_b = b;
    #1;
    ez = r ? ((ra == 0) ? '0 : mz[ra]) : hz;
    ep = r ? mp[ra] : hp;
    cmp(tag, "zero-word", rd_z, ez);
    cmp((tag == "R7") ? "R8" : tag, "plain", rd_p, ep);
    wd = s ? b : a;
    if (!rst_n) begin
      hz = '0; hp = '0;
    end else if (r) begin
      hz = ez; hp = ep;
    end
    if (w) begin
      if (wa != 0) mz[wa] = wd;
      mp[wa] = wd;
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R9: read bus cleared during and after reset
    cyc(0, 0, 0, 0, 0, '0, '0, "R9");
    cyc(0, 0, 0, 0, 3, '0, '0, "R9");
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 0, 5, '0, '0, "R9");

    // fill every word, bus chosen by parity; read bus must stay at zero (R5)
    for (int i = 0; i < N; i++)
      cyc(i[0], 1, 0, i, i, 32'hA000_0000 + i, 32'hB000_0000 + i, "R5");

    // R1: read back shows the bus picked per word
    for (int i = 0; i < N; i++)
      cyc(0, 0, 1, 0, i, '0, '0, "R1");

    // R3: write enable low with busy buses changes nothing
    for (int i = 0; i < N; i++)
      cyc(i[1], 0, 0, i, i, 32'hDEAD_0000 + i, 32'hBEEF_0000 + i, "R3");
    for (int i = 0; i < N; i++)
      cyc(0, 0, 1, 0, i, '0, '0, "R3");

    // R2: a single write touches only its own word
    cyc(1, 1, 0, 5, 0, 32'h1111_1111, 32'h5555_5555, "R2");
    for (int i = 0; i < N; i++)
      cyc(0, 0, 1, 0, i, '0, '0, "R2");

    // R6: read and write to the same address in one cycle returns old contents
    cyc(0, 1, 1, 3, 3, 32'h3333_CAFE, 32'h0, "R6");
    cyc(0, 0, 1, 0, 3, '0, '0, "R6");

    // R5: disabled read ignores address changes and writes, including to the shown word
    cyc(0, 0, 1, 0, 6, '0, '0, "R4");
    cyc(0, 1, 0, 6, 2, 32'h6666_0000, '0, "R5");
    cyc(1, 1, 0, 2, 7, '0, 32'h2222_0000, "R5");
    cyc(0, 0, 0, 0, 1, '0, '0, "R5");
    cyc(0, 0, 1, 0, 6, '0, '0, "R4");

    // R7: writes to word 0 ignored by the zero-word variant, stored by the plain one (R8)
    cyc(0, 1, 0, 0, 4, 32'hFFFF_FFFF, '0, "R7");
    cyc(0, 0, 1, 0, 0, '0, '0, "R7");
    cyc(1, 1, 1, 0, 0, '0, 32'h0F0F_0F0F, "R7");
    cyc(0, 0, 1, 0, 0, '0, '0, "R7");
    cyc(0, 0, 0, 0, 2, '0, '0, "R7");

    // R4: mixed random traffic
    for (int k = 0; k < 400; k++)
      cyc(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % N), int'($urandom % N),
          $urandom, $urandom, "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule